// File: doc/BRIEF.md
# Round-Robin Command Slot Issuer

This block sits in a storage host port and decides which queued command slot goes to the transport next. Outside registers hold the pending-command vector and the in-flight (active-tag) vector, and the block reads both. A slot is a candidate when its pending bit is set and its in-flight bit is clear. The block searches the candidates in rotating priority and offers the chosen slot on a valid/accept handshake. When the transport accepts the offer, the block records that slot as the current slot.

Priority rotates. After the start bit rises, slot 0 ranks highest. After each accepted issue, the slot one above the current slot ranks highest, and the search wraps past the top slot back to slot 0. When the start bit falls, the current slot returns to 0. Once no offer is outstanding, the block sends single-cycle clear pulses that the outside logic uses to wipe both vectors.

Top module: `slot_issuer`

## Requirements
- R1: While reset is active, and in the first cycle after it, `issueValid`, `clrPending` and `clrActive` are 0 and `curSlot` is 0.
- R2: No new offer is raised while `startEn` is 0. If `issueValid` is 0 in a cycle where `startEn` is 0, it is still 0 in the next cycle.
- R3: After `startEn` rises, the first offer is the lowest-numbered candidate, searching from slot 0. The offer appears one cycle after the rising edge is seen together with a candidate.
- R4: On an accepted offer (`issueValid` and `issueAccept` both 1 at a clock edge), `curSlot` takes the offered slot from the next cycle on. The next search then begins at `curSlot`+1 and wraps from NUM_SLOTS-1 to 0. For example, with `curSlot` 0 and pending bits 3h, slot 1 is chosen.
- R5: A slot whose bit in `activeVec` is 1 is never offered. While there is no candidate, `issueValid` stays 0 and `curSlot` keeps its value.
- R6: An offer stays up with an unchanged `issueSlot` until it is accepted. `issueValid` is 0 in the cycle after the accept.
- R7: When `startEn` falls, `curSlot` is 0 from the next cycle on.
- R8: After a fall of `startEn`, as soon as no offer is outstanding, `clrPending` and `clrActive` are 1 together for exactly one cycle. If no offer is up when the fall is seen, this is the second cycle after that fall. No offer is raised before the clear pulse has gone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEn | input | 1 | Run enable for command-list processing |
| pendingVec | input | NUM_SLOTS | Pending-command bits, one per slot |
| activeVec | input | NUM_SLOTS | In-flight bits, one per slot |
| issueAccept | input | 1 | Transport accepts the current offer |
| issueValid | output | 1 | An offer is presented |
| issueSlot | output | SLOT_W | Slot index being offered |
| curSlot | output | SLOT_W | Current command slot (last accepted) |
| clrPending | output | 1 | One-cycle pulse: wipe the pending vector |
| clrActive | output | 1 | One-cycle pulse: wipe the in-flight vector |

## Verification
The bench builds the block with NUM_SLOTS = 8. At this size every pairing of a current slot (0 to 7) with every one of the 256 pending patterns can be run, including the wrap past slot 7 and the case with no candidate. A second sweep runs all 256 in-flight masks against a full pending vector, searching from slot 0. Every case goes through a full stop and restart, so each of the 2300 or so runs exercises the zeroing of the current slot, the clear pulses and the reset of the search start.

// File: rtl/slot_issuer_pkg.sv
package slot_issuer_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadIssue;   // capture picked slot into the offer register
    logic commitCur;   // offer accepted: current slot takes offered slot
    logic zeroCur;     // start fell: current slot returns to zero
    logic useRotBase;  // search from current+1 instead of slot zero
  } issue_ctl_t;

endpackage

// File: rtl/slot_picker.sv
module slot_picker #(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic [NUM_SLOTS-1:0] candVec,
  input  logic [SLOT_W-1:0]    baseIdx,
  output logic [SLOT_W-1:0]    pickIdx,
  output logic                 pickAny
);

  localparam logic [SLOT_W:0] SLOT_COUNT = (SLOT_W+1)'(NUM_SLOTS);

  // Walk from the farthest position down to the base so the nearest wins.
  always_comb begin
    logic [SLOT_W:0] sumIdx;
    pickIdx = '0;
    pickAny = 1'b0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      sumIdx = {1'b0, baseIdx} + (SLOT_W+1)'(k);
      if (sumIdx >= SLOT_COUNT) sumIdx = sumIdx - SLOT_COUNT;
      if (candVec[sumIdx[SLOT_W-1:0]]) begin
        pickIdx = sumIdx[SLOT_W-1:0];
        pickAny = 1'b1;
      end
    end
  end

  always_comb begin
    if (pickAny) begin
      AST_PICK_IN_CAND: assert (candVec[pickIdx]); // R5
    end
  end

endmodule

// File: rtl/slot_datapath.sv
module slot_datapath
  import slot_issuer_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  issue_ctl_t           ctl,
  input  logic [NUM_SLOTS-1:0] pendingVec,
  input  logic [NUM_SLOTS-1:0] activeVec,
  output logic                 pickAny,
  output logic [SLOT_W-1:0]    issueSlot,
  output logic [SLOT_W-1:0]    curSlot
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  logic [NUM_SLOTS-1:0] candVec;
  logic [SLOT_W-1:0]    baseIdx;
  logic [SLOT_W-1:0]    pickIdx;

  assign candVec = pendingVec & ~activeVec;

  always_comb begin
    if (!ctl.useRotBase)          baseIdx = '0;
    else if (curSlot == LAST_SLOT) baseIdx = '0;
    else                           baseIdx = curSlot + 1'b1;
  end

  slot_picker #(.NUM_SLOTS(NUM_SLOTS)) picker (
    .candVec (candVec),
    .baseIdx (baseIdx),
    .pickIdx (pickIdx),
    .pickAny (pickAny)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      issueSlot <= '0;
      curSlot   <= '0;
    end else begin
      if (ctl.loadIssue) issueSlot <= pickIdx;
      if (ctl.zeroCur)        curSlot <= '0;
      else if (ctl.commitCur) curSlot <= issueSlot;
    end
  end

  AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.commitCur && !ctl.zeroCur) |=> $stable(curSlot)); // R5

endmodule

// File: rtl/slot_control.sv
module slot_control
  import slot_issuer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startEn,
  input  logic       issueAccept,
  input  logic       pickAny,
  output issue_ctl_t ctl,
  output logic       issueValid,
  output logic       clrPulse
);

  logic startQ;
  logic validQ;
  logic stopQ;
  logic clrQ;
  logic firstQ;

  logic startRise;
  logic startFall;
  logic acceptNow;
  logic canIssue;

  assign startRise = startEn & ~startQ;
  assign startFall = ~startEn & startQ;
  assign acceptNow = validQ & issueAccept;
  assign canIssue  = startEn & ~validQ & ~stopQ & ~clrQ & pickAny;

  always_comb begin
    ctl.loadIssue  = canIssue;
    ctl.commitCur  = acceptNow;
    ctl.zeroCur    = startFall;
    ctl.useRotBase = firstQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      validQ <= 1'b0;
      stopQ  <= 1'b0;
      clrQ   <= 1'b0;
      firstQ <= 1'b0;
    end else begin
      startQ <= startEn;

      if (acceptNow)     validQ <= 1'b0;
      else if (canIssue) validQ <= 1'b1;

      if (startFall)            stopQ <= 1'b1;
      else if (stopQ && !validQ) stopQ <= 1'b0;

      clrQ <= stopQ & ~validQ & ~startFall;

      if (startFall || startRise) firstQ <= 1'b0;
      else if (acceptNow)         firstQ <= 1'b1;
    end
  end

  assign issueValid = validQ;
  assign clrPulse   = clrQ;

  AST_NO_ISSUE_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!startEn && !issueValid) |=> !issueValid); // R2

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !issueAccept) |=> issueValid); // R6

  AST_DROP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueAccept) |=> !issueValid); // R6

  AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |=> !clrPulse); // R8

  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |-> !issueValid); // R8

endmodule

// File: rtl/slot_issuer.sv
module slot_issuer
  import slot_issuer_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startEn,
  input  logic [NUM_SLOTS-1:0] pendingVec,
  input  logic [NUM_SLOTS-1:0] activeVec,
  input  logic                 issueAccept,
  output logic                 issueValid,
  output logic [SLOT_W-1:0]    issueSlot,
  output logic [SLOT_W-1:0]    curSlot,
  output logic                 clrPending,
  output logic                 clrActive
);

  issue_ctl_t ctl;
  logic       pickAny;
  logic       clrPulse;

  slot_control control (
    .clk         (clk),
    .rstN        (rstN),
    .startEn     (startEn),
    .issueAccept (issueAccept),
    .pickAny     (pickAny),
    .ctl         (ctl),
    .issueValid  (issueValid),
    .clrPulse    (clrPulse)
  );

  slot_datapath #(.NUM_SLOTS(NUM_SLOTS)) datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .pendingVec (pendingVec),
    .activeVec  (activeVec),
    .pickAny    (pickAny),
    .issueSlot  (issueSlot),
    .curSlot    (curSlot)
  );

  assign clrPending = clrPulse;
  assign clrActive  = clrPulse;

  AST_FELL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $fell(startEn) |=> (curSlot == '0)); // R7

  AST_OFFER_IS_IDLE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    $rose(issueValid) |->
      (((($past(pendingVec) & ~$past(activeVec)) >> issueSlot) & NUM_SLOTS'(1)) != '0)); // R5

endmodule

// File: tb/tb_slot_issuer.sv
module tb_slot_issuer;

  localparam int N = 8;
  localparam int W = $clog2(N);

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startEn = 1'b0;
  logic         issueAccept = 1'b0;
  logic [N-1:0] pendingVec = '0;
  logic [N-1:0] activeVec = '0;
  logic         issueValid;
  logic [W-1:0] issueSlot;
  logic [W-1:0] curSlot;
  logic         clrPending;
  logic         clrActive;

  int nChecks = 0;
  int nFails  = 0;

  slot_issuer #(.NUM_SLOTS(N)) dut (
    .clk         (clk),
    .rstN        (rstN),
    .startEn     (startEn),
    .pendingVec  (pendingVec),
    .activeVec   (activeVec),
    .issueAccept (issueAccept),
    .issueValid  (issueValid),
    .issueSlot   (issueSlot),
    .curSlot     (curSlot),
    .clrPending  (clrPending),
    .clrActive   (clrActive)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  // first candidate at or after base, cyclic; -1 if none
  function automatic int expPick(input int base, input logic [N-1:0] cand);
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (base + k) % N;
      if (cand[idx]) return idx;
    end
    return -1;
  endfunction

  // stop the port, see the zeroing and clear pulse, then restart
  task automatic stopPort();
    if (issueValid) begin
      issueAccept = 1'b1;
      activeVec[issueSlot] = 1'b1;
    end
    startEn = 1'b0;
    tick();
    issueAccept = 1'b0;
    chk("R7 curSlot after stop", int'(curSlot), 0);
    chk("R2 no offer while stopped", int'(issueValid), 0);
    tick();
    chk("R8 clrPending pulse", int'(clrPending), 1);
    chk("R8 clrActive pulse", int'(clrActive), 1);
    pendingVec = '0;
    activeVec  = '0;
    tick();
    chk("R8 clear pulse one cycle", int'(clrPending), 0);
    startEn = 1'b1;
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R1 valid in reset", int'(issueValid), 0);
    tick();
    tick();
    rstN = 1'b1;
    tick();
    chk("R1 valid after reset", int'(issueValid), 0);
    chk("R1 curSlot after reset", int'(curSlot), 0);
    chk("R1 clrPending after reset", int'(clrPending), 0);
    chk("R1 clrActive after reset", int'(clrActive), 0);

    // R2: pending work but start held low
    pendingVec = 8'h5a;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R2 no offer with start low", int'(issueValid), 0);
    end
    pendingVec = '0;
    startEn = 1'b1;
    tick();

    // Sweep: every current slot against every pending pattern
    for (int c = 0; c < N; c++) begin
      for (int p = 0; p < (1 << N); p++) begin
        int e;
        stopPort();
        pendingVec = N'(1) << c;
        tick();
        chk("R3 offer after start", int'(issueValid), 1);
        chk("R3 first slot from zero", int'(issueSlot), c);
        tick();
        chk("R6 offer held", int'(issueValid), 1);
        chk("R6 slot held", int'(issueSlot), c);
        issueAccept = 1'b1;
        activeVec   = N'(1) << c;
        tick();
        issueAccept = 1'b0;
        chk("R6 drop after accept", int'(issueValid), 0);
        chk("R4 curSlot takes accepted slot", int'(curSlot), c);
        pendingVec = N'(p);
        activeVec  = '0;
        tick();
        e = expPick((c + 1) % N, N'(p));
        if (e < 0) begin
          chk("R5 no offer without candidate", int'(issueValid), 0);
          tick();
          chk("R5 still no offer", int'(issueValid), 0);
          chk("R5 curSlot holds", int'(curSlot), c);
        end else begin
          chk("R4 rotated offer valid", int'(issueValid), 1);
          chk("R4 rotated slot", int'(issueSlot), e);
        end
      end
    end

    // Sweep: in-flight masks against a full pending vector
    for (int a = 0; a < (1 << N); a++) begin
      int e;
      stopPort();
      pendingVec = '1;
      activeVec  = N'(a);
      tick();
      e = expPick(0, ~N'(a));
      if (e < 0) begin
        chk("R5 all in flight no offer", int'(issueValid), 0);
      end else begin
        chk("R5 offer skips in-flight", int'(issueValid), 1);
        chk("R5 skipped slot", int'(issueSlot), e);
      end
    end

    summary();
    $finish;
  end

endmodule